// File: doc/BRIEF.md
# Framed UART Transmitter over a Word Shifter

This block sends asynchronous serial characters on one output line. Each character holds 5 to 8 bits and takes one or two stop bits. There is no parity. When a character is written, the block frames it at once into a word and queues that word in an 8-entry FIFO. A word shifter then sends each word least significant bit first. Each bit is held for a period set by a programmable divider that runs off the system clock. While the enable input is low the line rests high and the queue is left untouched.

A write can also queue a filler word of all ones in place of a character. Software uses the filler to stop the transmitter cleanly. It queues a filler after the last character and waits for the hold-empty status. It then drops the enable: by that time the last real frame has been sent and the shifter is only sending idle-high bits. Two more status flags record errors and stay set until reset. Overflow records a write refused because the queue was full. Underflow records a word slot that came up while the queue was empty; the line stays high for that slot.

Top module: `framed_uart_tx`

## Requirements
- R1: After reset the line output is 1, hold-empty is 1, the FIFO-full flag is 0, write-ready is 1, and both sticky error flags are 0.
- R2: The length select sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. A frame is a 0 start bit, then the data bits least significant first, then the stop bit(s) at 1. Data bits above the selected length are never sent.
- R3: A write while 8 words are queued is discarded and sets the sticky overflow flag. The discarded character never appears on the line.
- R4: If the shifter needs a new word while enabled and the FIFO is empty, the sticky underflow flag is set and the line stays at 1 for that whole word.
- R5: Every bit lasts exactly 2 x (divisor + 1) clock cycles.
- R6: While the enable input is 0, the line is 1 and queued words are not consumed, so hold-empty stays 0.
- R7: Hold-empty is 1 exactly when the FIFO holds no words. FIFO-full is 1 exactly when it holds 8 words. Write-ready is the inverse of FIFO-full.
- R8: A write with the filler input set queues an all-ones word. That word keeps the line high for a whole word time and does not set underflow.
- R9: With the second-stop input set, the frame gets one extra stop bit. Frames are sent back to back: the next start bit begins exactly (data bits + stop bits + 1) bit periods after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txEnable | input | 1 | Transmit enable; 0 holds the line high and stops the shifter |
| charSel | input | 2 | Data length select (0..3 gives 5..8 bits) |
| twoStop | input | 1 | Adds a second stop bit |
| divisor | input | 16 | Bit-clock divider value; bit period is 2 x (divisor + 1) clocks |
| wrValid | input | 1 | Write strobe for one queue entry |
| wrFill | input | 1 | With wrValid, queue an all-ones filler word instead of a character |
| wrData | input | 8 | Character to frame and queue |
| wrReady | output | 1 | The queue can accept a write |
| txLine | output | 1 | Serial line output |
| fifoFull | output | 1 | 8 words are queued |
| holdEmpty | output | 1 | No words are queued |
| overflowFlag | output | 1 | Sticky: a write was refused because the queue was full |
| underflowFlag | output | 1 | Sticky: a word slot came up with the queue empty while enabled |

## Verification
A wrong frame mask shows on the line within the same frame. It appears as a data bit sampled at the wrong value, or as a low stop bit one bit period after the last data bit. A wrong bit counter or divider shows up by the second frame: the start-to-start spacing changes by a whole number of clocks, and the length of a low start bit differs from 2 x (divisor + 1). A wrong FIFO count shows up on the status outputs as soon as the eighth or ninth write lands. It can also show later, as a dropped or repeated character in a burst of queued frames, or as underflow setting one word early.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

  // Strobes sent from the sequencing control to the datapath each cycle
  typedef struct packed {
    logic loadWord;   // take the next word into the shifter
    logic shiftBit;   // advance the shifter by one bit
    logic holdLine;   // transmitter disabled: force the line high
  } ftx_strobe_t;

endpackage

// File: rtl/ftx_fifo.sv
module ftx_fifo #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] dIn,
  input  logic             pop,
  output logic [WIDTH-1:0] dOut,
  output logic             full,
  output logic             empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign full   = (count == FULL_CNT);
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dOut   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= dIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/ftx_frame_builder.sv
module ftx_frame_builder #(
  parameter int MAX_DATA = 8,
  parameter int MIN_DATA = 5,
  parameter int SEL_W    = 2,
  parameter int WORD_W   = MAX_DATA + 3,
  parameter int LEN_W    = $clog2(WORD_W + 1)
) (
  input  logic [MAX_DATA-1:0] charData,
  input  logic [SEL_W-1:0]    charSel,
  input  logic                twoStop,
  output logic [WORD_W-1:0]   frameWord,
  output logic [LEN_W-1:0]    wordLen
);

  logic [LEN_W-1:0]  dataBits;
  logic [WORD_W-1:0] dataMask;
  logic [WORD_W-1:0] stopMask;
  logic [WORD_W-1:0] shifted;

  assign dataBits = LEN_W'(MIN_DATA) + LEN_W'(charSel);
  // start bit + data bits + stop bit(s)
  assign wordLen  = dataBits + LEN_W'(twoStop) + LEN_W'(2);

  // Per-position masks: data occupies 1..dataBits, stop bit(s) directly above
  for (genvar i = 0; i < WORD_W; i++) begin : g_mask
    localparam logic [LEN_W-1:0] POS = LEN_W'(i);
    assign dataMask[i] = (POS != '0) && (POS <= dataBits);
    assign stopMask[i] = (POS == dataBits + LEN_W'(1)) ||
                         (twoStop && (POS == dataBits + LEN_W'(2)));
  end

  assign shifted   = {{(WORD_W-MAX_DATA){1'b0}}, charData} << 1;
  assign frameWord = (shifted & dataMask) | stopMask;

endmodule

// File: rtl/ftx_control.sv
module ftx_control
  import ftx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEnable,
  input  logic [DIV_W-1:0] divisor,
  input  logic [LEN_W-1:0] wordLen,
  output ftx_strobe_t      strobe
);

  logic             active;
  logic [DIV_W:0]   divCnt;
  logic [DIV_W:0]   lastCnt;
  logic [LEN_W-1:0] bitIdx;
  logic [LEN_W-1:0] lenQ;
  logic             bitEnd;
  logic             lastBit;

  // Bit period is 2*(divisor+1) clocks, so the count ends at 2*divisor+1
  assign lastCnt = {divisor, 1'b1};
  assign bitEnd  = active && (divCnt == lastCnt);
  assign lastBit = (bitIdx == lenQ - LEN_W'(1));

  always_comb begin
    strobe          = '0;
    strobe.holdLine = !txEnable;
    strobe.loadWord = txEnable && (!active || (bitEnd && lastBit));
    strobe.shiftBit = txEnable && bitEnd && !lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
      lenQ   <= '0;
    end else if (!txEnable) begin
      active <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (!active) begin
      active <= 1'b1;
      divCnt <= '0;
      bitIdx <= '0;
      lenQ   <= wordLen;
    end else if (bitEnd) begin
      divCnt <= '0;
      if (lastBit) begin
        bitIdx <= '0;
        lenQ   <= wordLen;
      end else begin
        bitIdx <= bitIdx + LEN_W'(1);
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

endmodule

// File: rtl/ftx_datapath.sv
module ftx_datapath
  import ftx_pkg::*;
#(
  parameter int MAX_DATA = 8,
  parameter int MIN_DATA = 5,
  parameter int SEL_W    = 2,
  parameter int DEPTH    = 8,
  parameter int WORD_W   = MAX_DATA + 3,
  parameter int LEN_W    = $clog2(WORD_W + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ftx_strobe_t         strobe,
  input  logic                wrValid,
  input  logic                wrFill,
  input  logic [MAX_DATA-1:0] wrData,
  input  logic [SEL_W-1:0]    charSel,
  input  logic                twoStop,
  output logic [LEN_W-1:0]    wordLen,
  output logic                wrReady,
  output logic                txLine,
  output logic                fifoFull,
  output logic                holdEmpty,
  output logic                overflowFlag,
  output logic                underflowFlag
);

  logic [WORD_W-1:0] frameWord;
  logic [WORD_W-1:0] pushWord;
  logic [WORD_W-1:0] headWord;
  logic [WORD_W-1:0] shiftReg;
  logic              fifoEmpty;
  logic              lineQ;
  logic              overQ, underQ;

  ftx_frame_builder #(
    .MAX_DATA(MAX_DATA), .MIN_DATA(MIN_DATA), .SEL_W(SEL_W),
    .WORD_W(WORD_W), .LEN_W(LEN_W)
  ) u_build (
    .charData (wrData),
    .charSel  (charSel),
    .twoStop  (twoStop),
    .frameWord(frameWord),
    .wordLen  (wordLen)
  );

  assign pushWord = wrFill ? '1 : frameWord;

  ftx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk  (clk),
    .rstN (rstN),
    .push (wrValid),
    .dIn  (pushWord),
    .pop  (strobe.loadWord),
    .dOut (headWord),
    .full (fifoFull),
    .empty(fifoEmpty)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
      lineQ    <= 1'b1;
      overQ    <= 1'b0;
      underQ   <= 1'b0;
    end else begin
      if (wrValid && fifoFull) overQ <= 1'b1;
      if (strobe.holdLine) begin
        lineQ <= 1'b1;
      end else if (strobe.loadWord) begin
        if (fifoEmpty) begin
          shiftReg <= '1;
          lineQ    <= 1'b1;
          underQ   <= 1'b1;
        end else begin
          shiftReg <= headWord;
          lineQ    <= headWord[0];
        end
      end else if (strobe.shiftBit) begin
        shiftReg <= {1'b1, shiftReg[WORD_W-1:1]};
        lineQ    <= shiftReg[1];
      end
    end
  end

  assign wrReady       = !fifoFull;
  assign holdEmpty     = fifoEmpty;
  assign txLine        = lineQ;
  assign overflowFlag  = overQ;
  assign underflowFlag = underQ;

endmodule

// File: rtl/framed_uart_tx.sv
module framed_uart_tx
  import ftx_pkg::*;
#(
  parameter int MAX_DATA = 8,
  parameter int MIN_DATA = 5,
  parameter int SEL_W    = 2,
  parameter int DEPTH    = 8,
  parameter int DIV_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txEnable,
  input  logic [SEL_W-1:0]    charSel,
  input  logic                twoStop,
  input  logic [DIV_W-1:0]    divisor,
  input  logic                wrValid,
  input  logic                wrFill,
  input  logic [MAX_DATA-1:0] wrData,
  output logic                wrReady,
  output logic                txLine,
  output logic                fifoFull,
  output logic                holdEmpty,
  output logic                overflowFlag,
  output logic                underflowFlag
);

  localparam int WORD_W = MAX_DATA + 3;
  localparam int LEN_W  = $clog2(WORD_W + 1);

  ftx_strobe_t      strobe;
  logic [LEN_W-1:0] wordLen;

  ftx_control #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .txEnable(txEnable),
    .divisor (divisor),
    .wordLen (wordLen),
    .strobe  (strobe)
  );

  ftx_datapath #(
    .MAX_DATA(MAX_DATA), .MIN_DATA(MIN_DATA), .SEL_W(SEL_W),
    .DEPTH(DEPTH), .WORD_W(WORD_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrValid      (wrValid),
    .wrFill       (wrFill),
    .wrData       (wrData),
    .charSel      (charSel),
    .twoStop      (twoStop),
    .wordLen      (wordLen),
    .wrReady      (wrReady),
    .txLine       (txLine),
    .fifoFull     (fifoFull),
    .holdEmpty    (holdEmpty),
    .overflowFlag (overflowFlag),
    .underflowFlag(underflowFlag)
  );

endmodule

// File: rtl/ftx_checker.sv
module ftx_checker (
  input logic clk,
  input logic rstN,
  input logic txEnable,
  input logic wrValid,
  input logic wrReady,
  input logic txLine,
  input logic fifoFull,
  input logic holdEmpty,
  input logic overflowFlag,
  input logic underflowFlag
);

  assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> txLine);

  assert_ready_vs_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !wrReady);

  assert_not_full_and_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && holdEmpty));

  assert_overflow_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && fifoFull) |=> overflowFlag);

  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  assert_overflow_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflowFlag) |-> $past(wrValid && fifoFull));

  assert_underflow_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    underflowFlag |=> underflowFlag);

  assert_underflow_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underflowFlag) |-> $past(holdEmpty && txEnable));

endmodule

bind framed_uart_tx ftx_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .txEnable     (txEnable),
  .wrValid      (wrValid),
  .wrReady      (wrReady),
  .txLine       (txLine),
  .fifoFull     (fifoFull),
  .holdEmpty    (holdEmpty),
  .overflowFlag (overflowFlag),
  .underflowFlag(underflowFlag)
);

// File: tb/framed_uart_tx_tb.sv
module framed_uart_tx_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txEnable = 1'b0;
  logic [1:0]  charSel = 2'd3;
  logic        twoStop = 1'b0;
  logic [15:0] divisor = 16'd0;
  logic        wrValid = 1'b0;
  logic        wrFill = 1'b0;
  logic [7:0]  wrData = 8'd0;
  logic        wrReady, txLine, fifoFull, holdEmpty, overflowFlag, underflowFlag;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  framed_uart_tx u_dut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .charSel(charSel),
    .twoStop(twoStop), .divisor(divisor), .wrValid(wrValid), .wrFill(wrFill),
    .wrData(wrData), .wrReady(wrReady), .txLine(txLine), .fifoFull(fifoFull),
    .holdEmpty(holdEmpty), .overflowFlag(overflowFlag), .underflowFlag(underflowFlag)
  );

  typedef struct packed {
    logic [1:0] sel;
    logic       two;
    logic [7:0] data;   // kept odd so the start bit ends on a rising edge
    logic [7:0] div;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{2'd3, 1'b0, 8'hA5, 8'd3},
    '{2'd0, 1'b0, 8'hF3, 8'd1},
    '{2'd1, 1'b1, 8'h2D, 8'd2},
    '{2'd2, 1'b0, 8'h55, 8'd0},
    '{2'd3, 1'b1, 8'hFF, 8'd4},
    '{2'd2, 1'b1, 8'h81, 8'd5}
  };

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    txEnable = 1'b0;
    wrValid = 1'b0;
    wrFill = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeWord(input logic [7:0] d, input logic fill);
    wrData = d;
    wrFill = fill;
    wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
    wrFill = 1'b0;
  endtask

  // Line receiver: waits for a start bit, measures its length, samples mid-bit
  task automatic rxFrame(input int p, input int nData, input int nStop,
                         output logic [7:0] d, output logic stopOk,
                         output int lowLen, output int startCyc);
    while (txLine === 1'b1) @(negedge clk);
    startCyc = cyc;
    lowLen = 0;
    while (txLine === 1'b0) begin
      lowLen++;
      @(negedge clk);
    end
    repeat (p / 2) @(negedge clk);
    d = '0;
    for (int i = 0; i < nData; i++) begin
      d[i] = txLine;
      if (i < nData - 1) repeat (p) @(negedge clk);
    end
    stopOk = 1'b1;
    for (int s = 0; s < nStop; s++) begin
      repeat (p) @(negedge clk);
      stopOk = stopOk & txLine;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    logic stopOk;
    int lowLen, st0, st1, lows;

    doReset();
    // R1 reset state
    check("R1", "txLine after reset", txLine, 1);
    check("R1", "holdEmpty after reset", holdEmpty, 1);
    check("R1", "fifoFull after reset", fifoFull, 0);
    check("R1", "wrReady after reset", wrReady, 1);
    check("R1", "overflow after reset", overflowFlag, 0);
    check("R1", "underflow after reset", underflowFlag, 0);

    // Table walk: one framed character plus filler per vector
    for (int v = 0; v < NVEC; v++) begin
      int nData, nStop, p, bad;
      logic [7:0] expData;
      nData = 5 + int'(VECS[v].sel);
      nStop = VECS[v].two ? 2 : 1;
      p = 2 * (int'(VECS[v].div) + 1);
      expData = VECS[v].data & 8'((1 << nData) - 1);
      charSel = VECS[v].sel;
      twoStop = VECS[v].two;
      divisor = {8'd0, VECS[v].div};
      writeWord(VECS[v].data, 1'b0);
      writeWord(8'h00, 1'b1);
      txEnable = 1'b1;
      rxFrame(p, nData, nStop, rx, stopOk, lowLen, st0);
      check("R2", $sformatf("vec%0d data", v), rx, expData);
      check("R2", $sformatf("vec%0d stop bits high", v), stopOk, 1);
      check("R5", $sformatf("vec%0d start bit length", v), lowLen, p);
      bad = 0;
      while (!holdEmpty) begin
        if (!txLine) bad++;
        @(negedge clk);
      end
      repeat (p) begin
        if (!txLine) bad++;
        @(negedge clk);
      end
      txEnable = 1'b0;
      @(negedge clk);
      check("R8", $sformatf("vec%0d filler keeps line high", v), bad, 0);
      check("R8", $sformatf("vec%0d filler is no underflow", v), underflowFlag, 0);
      check("R6", $sformatf("vec%0d line high when disabled", v), txLine, 1);
    end

    // R6: queued words held while disabled; R9 back-to-back spacing; R4 underflow
    doReset();
    charSel = 2'd1; twoStop = 1'b1; divisor = 16'd2;   // 6 data, 2 stop, P=6, L=9
    writeWord(8'h21, 1'b0);
    writeWord(8'h13, 1'b0);
    writeWord(8'h3F, 1'b0);
    lows = 0;
    repeat (200) begin
      if (!txLine) lows++;
      @(negedge clk);
    end
    check("R6", "line stays high while disabled", lows, 0);
    check("R6", "words not consumed while disabled", holdEmpty, 0);
    txEnable = 1'b1;
    rxFrame(6, 6, 2, rx, stopOk, lowLen, st0);
    check("R9", "burst frame 0 data", rx, 8'h21);
    check("R9", "burst frame 0 two stop bits", stopOk, 1);
    rxFrame(6, 6, 2, rx, stopOk, lowLen, st1);
    check("R9", "burst frame 1 data", rx, 8'h13);
    check("R9", "start-to-start spacing", st1 - st0, 9 * 6);
    st0 = st1;
    rxFrame(6, 6, 2, rx, stopOk, lowLen, st1);
    check("R9", "burst frame 2 data", rx, 8'h3F);
    check("R9", "start-to-start spacing 2", st1 - st0, 9 * 6);
    lows = 0;
    repeat (2 * 9 * 6) begin
      if (!txLine) lows++;
      @(negedge clk);
    end
    check("R4", "line high on empty slot", lows, 0);
    check("R4", "underflow set on empty slot", underflowFlag, 1);
    check("R7", "holdEmpty with queue drained", holdEmpty, 1);
    txEnable = 1'b0;
    @(negedge clk);

    // R3 / R7: fill the queue, overflow, then drain and confirm the discarded word is absent
    doReset();
    charSel = 2'd3; twoStop = 1'b0; divisor = 16'd0;   // 8 data, 1 stop, P=2, L=10
    for (int k = 0; k < 8; k++) begin
      check("R7", $sformatf("ready before write %0d", k), wrReady, 1);
      writeWord(8'((2 * k) + 1), 1'b0);
    end
    check("R7", "full after 8 writes", fifoFull, 1);
    check("R7", "ready low when full", wrReady, 0);
    check("R7", "holdEmpty low when full", holdEmpty, 0);
    check("R3", "no overflow before extra write", overflowFlag, 0);
    writeWord(8'h7F, 1'b0);
    check("R3", "overflow after write to full queue", overflowFlag, 1);
    txEnable = 1'b1;
    for (int k = 0; k < 8; k++) begin
      rxFrame(2, 8, 1, rx, stopOk, lowLen, st0);
      check("R3", $sformatf("queued frame %0d data", k), rx, 8'((2 * k) + 1));
    end
    lows = 0;
    repeat (3 * 10 * 2) begin
      if (!txLine) lows++;
      @(negedge clk);
    end
    check("R3", "discarded word never sent", lows, 0);
    check("R3", "overflow remains set", overflowFlag, 1);
    check("R4", "underflow after queue ran dry", underflowFlag, 1);
    txEnable = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule